// File: doc/BRIEF.md
# Multithreaded Dispatch Thread Ranker

Each cycle this block decides which hardware thread is allowed to move instructions out of the shared decode-to-dispatch buffer. For every thread it forms a dispatch count, an eligibility bit and a score. It then orders all threads into a complete ranking: eligibility first, then score, then how long ago the thread last dispatched, and finally thread index. The top-ranked thread and its count are the winner. The full ranking is also published, so that a single-queue dispatch stage can walk the threads in rank order and stop at the first one that actually moves an instruction.

Two scoring rules are available, chosen by one input. The occupancy rule rewards threads that hold few issue-queue entries: the score is the total queue size minus the thread's occupancy and a static bias, and it floors at zero. The age rule rewards threads that have waited longest: the score is the current cycle minus the thread's last dispatch cycle, in modular arithmetic. The block keeps one last-dispatch timestamp per thread. The dispatch stage reports which thread dispatched, and the block stamps that thread with the current cycle.

All outputs are registered, so the ranking seen in cycle k+1 is computed from the inputs and timestamps of cycle k.

Top module: `dispatch_thread_arbiter`

## Requirements
- R1: A thread's dispatch count is its available-instruction count, limited to DISP_W. The reported `winner_cnt` is the count of the rank-0 thread.
- R2: A thread with zero available instructions is ineligible. Every eligible thread ranks ahead of every ineligible thread, and `winner_valid` is high whenever any thread had instructions in the previous cycle.
- R3: When `policy_occ` is 1, a thread's score is IQ_SLOTS minus the sum of its `iq_occ` and `occ_bias` fields.
- R4: Under the occupancy rule, a thread whose occupancy plus bias reaches or exceeds IQ_SLOTS scores 0 and does not wrap.
- R5: When `policy_occ` is 0, a thread's score is `cycle_now` minus its last-dispatch stamp, modulo 2^TS_W.
- R6: Within the same eligibility class, a higher score ranks earlier. `rank_order` holds the thread index of rank p in bits [p*IDW +: IDW], with p = 0 the best, and it is always a permutation of all threads.
- R7: When scores are equal, the thread with the larger age (`cycle_now` minus its stamp, modulo 2^TS_W) ranks earlier. If that is also equal, the lower thread index ranks earlier.
- R8: If no thread is eligible, `winner_valid` is 0 and `no_insn` is 1 in the next cycle.
- R9: When `disp_done` is high at a clock edge, the stamp of thread `disp_done_id` becomes that cycle's `cycle_now`. The ranking registered at that same edge still uses the old stamp.
- R10: Outputs change only at the clock edge, one cycle after their inputs. Synchronous reset clears all stamps to 0 and sets `winner_valid`=0, `winner_id`=0, `winner_cnt`=0, `no_insn`=1 and `rank_order` to the identity (thread p in slot p).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| policy_occ | input | 1 | 1 selects the occupancy score rule, 0 selects the age score rule |
| cycle_now | input | TS_W | Current cycle number |
| avail_cnt | input | NT*CNT_W | Per-thread count of instructions waiting, thread t at [t*CNT_W +: CNT_W] |
| iq_occ | input | NT*OCC_W | Per-thread issue-queue occupancy |
| occ_bias | input | NT*OCC_W | Per-thread static bias added to occupancy |
| disp_done | input | 1 | A thread dispatched at least one instruction this cycle |
| disp_done_id | input | IDW | Thread that dispatched |
| winner_valid | output | 1 | Rank-0 thread is eligible |
| winner_id | output | IDW | Rank-0 thread index |
| winner_cnt | output | CNT_OW | Dispatch count of the rank-0 thread |
| rank_order | output | NT*IDW | Full ranking, slot 0 best |
| no_insn | output | 1 | No thread had instructions to dispatch |

## Verification
The bench uses the default parameters: four threads, a dispatch width of 4, 32 queue slots, 6-bit occupancy and bias fields, and 16-bit timestamps. Occupancy and bias are each up to 63, so their sum can pass 32 and reach the zero floor, and available counts above 4 exercise the dispatch-width cap. Directed phases set up tied scores with distinct stamps to show the age and index tie-breaks. A random phase starts `cycle_now` just below 2^16, so the age score is exercised across the timestamp wrap.

// File: rtl/dta_pkg.sv
package dta_pkg;

  typedef enum logic {
    SCORE_AGE = 1'b0,
    SCORE_OCC = 1'b1
  } score_rule_e;

endpackage

// File: rtl/dta_stamp_file.sv
module dta_stamp_file #(
  parameter int NT   = 4,
  parameter int TS_W = 16,
  parameter int IDW  = (NT > 1) ? $clog2(NT) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [IDW-1:0]    wr_id,
  input  logic [TS_W-1:0]   wr_val,
  output logic [NT*TS_W-1:0] stamps
);

  logic [TS_W-1:0] stamp_q [NT];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int t = 0; t < NT; t++) stamp_q[t] <= '0;
    end else if (wr_en) begin
      stamp_q[wr_id] <= wr_val;
    end
  end

  for (genvar g = 0; g < NT; g++) begin : g_out
    assign stamps[g*TS_W +: TS_W] = stamp_q[g];
  end

endmodule

// File: rtl/dta_score_unit.sv
module dta_score_unit
  import dta_pkg::*;
#(
  parameter int CNT_W    = 4,
  parameter int OCC_W    = 6,
  parameter int TS_W     = 16,
  parameter int DISP_W   = 4,
  parameter int IQ_SLOTS = 32,
  parameter int CNT_OW   = $clog2(DISP_W + 1)
) (
  input  score_rule_e       rule,
  input  logic [TS_W-1:0]   cycle_now,
  input  logic [TS_W-1:0]   last_stamp,
  input  logic [CNT_W-1:0]  avail,
  input  logic [OCC_W-1:0]  occ,
  input  logic [OCC_W-1:0]  bias,
  output logic              elig,
  output logic [CNT_OW-1:0] cnt,
  output logic [TS_W-1:0]   score,
  output logic [TS_W-1:0]   age
);

  localparam int SUM_W = OCC_W + 1;

  logic [SUM_W-1:0] load_sum;
  logic [TS_W-1:0]  load_ext;
  logic [TS_W-1:0]  occ_score;

  always_comb begin
    load_sum = SUM_W'(occ) + SUM_W'(bias);
    load_ext = TS_W'(load_sum);
    if (load_ext >= TS_W'(IQ_SLOTS)) occ_score = '0;
    else                             occ_score = TS_W'(IQ_SLOTS) - load_ext;
  end

  always_comb begin
    age   = cycle_now - last_stamp;
    score = (rule == SCORE_OCC) ? occ_score : age;
    elig  = (avail != '0);
    if (int'(avail) > DISP_W) cnt = CNT_OW'(DISP_W);
    else                      cnt = CNT_OW'(avail);
  end

endmodule

// File: rtl/dta_rank_net.sv
module dta_rank_net #(
  parameter int NT    = 4,
  parameter int KEY_W = 33,
  parameter int IDW   = (NT > 1) ? $clog2(NT) : 1
) (
  input  logic [NT*KEY_W-1:0] keys,
  output logic [NT*IDW-1:0]   order
);

  logic [KEY_W-1:0] key_a [NT];
  logic [NT-1:0]    beats [NT];
  logic [IDW-1:0]   pos   [NT];

  for (genvar g = 0; g < NT; g++) begin : g_unpack
    assign key_a[g] = keys[g*KEY_W +: KEY_W];
  end

  for (genvar i = 0; i < NT; i++) begin : g_row
    for (genvar j = 0; j < NT; j++) begin : g_col
      if (i == j) begin : g_self
        assign beats[i][j] = 1'b0;
      end else if (i < j) begin : g_lo
        assign beats[i][j] = (key_a[i] >= key_a[j]);
      end else begin : g_hi
        assign beats[i][j] = (key_a[i] > key_a[j]);
      end
    end
  end

  always_comb begin
    for (int i = 0; i < NT; i++) begin
      pos[i] = '0;
      for (int j = 0; j < NT; j++) begin
        if (beats[j][i]) pos[i] = pos[i] + IDW'(1);
      end
    end
  end

  always_comb begin
    order = '0;
    for (int p = 0; p < NT; p++) begin
      for (int i = 0; i < NT; i++) begin
        if (int'(pos[i]) == p) order[p*IDW +: IDW] = IDW'(i);
      end
    end
  end

endmodule

// File: rtl/dispatch_thread_arbiter.sv
module dispatch_thread_arbiter
  import dta_pkg::*;
#(
  parameter int NT       = 4,
  parameter int CNT_W    = 4,
  parameter int OCC_W    = 6,
  parameter int TS_W     = 16,
  parameter int DISP_W   = 4,
  parameter int IQ_SLOTS = 32,
  parameter int IDW      = (NT > 1) ? $clog2(NT) : 1,
  parameter int CNT_OW   = $clog2(DISP_W + 1)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 policy_occ,
  input  logic [TS_W-1:0]      cycle_now,
  input  logic [NT*CNT_W-1:0]  avail_cnt,
  input  logic [NT*OCC_W-1:0]  iq_occ,
  input  logic [NT*OCC_W-1:0]  occ_bias,
  input  logic                 disp_done,
  input  logic [IDW-1:0]       disp_done_id,
  output logic                 winner_valid,
  output logic [IDW-1:0]       winner_id,
  output logic [CNT_OW-1:0]    winner_cnt,
  output logic [NT*IDW-1:0]    rank_order,
  output logic                 no_insn
);

  localparam int KEY_W = 2 * TS_W + 1;

  score_rule_e         rule;
  logic [NT*TS_W-1:0]  stamps;
  logic [NT*KEY_W-1:0] keys;
  logic [NT-1:0]       elig;
  logic [CNT_OW-1:0]   cnt   [NT];
  logic [NT*IDW-1:0]   order_c;
  logic [NT*IDW-1:0]   ident;
  logic [IDW-1:0]      top_id;

  assign rule = policy_occ ? SCORE_OCC : SCORE_AGE;

  dta_stamp_file #(.NT(NT), .TS_W(TS_W), .IDW(IDW)) u_stamps (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (disp_done),
    .wr_id  (disp_done_id),
    .wr_val (cycle_now),
    .stamps (stamps)
  );

  for (genvar g = 0; g < NT; g++) begin : g_thr
    logic [TS_W-1:0] score_g;
    logic [TS_W-1:0] age_g;
    dta_score_unit #(
      .CNT_W(CNT_W), .OCC_W(OCC_W), .TS_W(TS_W),
      .DISP_W(DISP_W), .IQ_SLOTS(IQ_SLOTS), .CNT_OW(CNT_OW)
    ) u_score (
      .rule       (rule),
      .cycle_now  (cycle_now),
      .last_stamp (stamps[g*TS_W +: TS_W]),
      .avail      (avail_cnt[g*CNT_W +: CNT_W]),
      .occ        (iq_occ[g*OCC_W +: OCC_W]),
      .bias       (occ_bias[g*OCC_W +: OCC_W]),
      .elig       (elig[g]),
      .cnt        (cnt[g]),
      .score      (score_g),
      .age        (age_g)
    );
    assign keys[g*KEY_W +: KEY_W] = {elig[g], score_g, age_g};
    assign ident[g*IDW +: IDW]    = IDW'(g);
  end

  dta_rank_net #(.NT(NT), .KEY_W(KEY_W), .IDW(IDW)) u_rank (
    .keys  (keys),
    .order (order_c)
  );

  assign top_id = order_c[IDW-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      winner_valid <= 1'b0;
      winner_id    <= '0;
      winner_cnt   <= '0;
      rank_order   <= ident;
      no_insn      <= 1'b1;
    end else begin
      winner_valid <= elig[top_id];
      winner_id    <= top_id;
      winner_cnt   <= cnt[top_id];
      rank_order   <= order_c;
      no_insn      <= ~elig[top_id];
    end
  end

endmodule

// File: rtl/dta_arb_chk.sv
module dta_arb_chk #(
  parameter int NT     = 4,
  parameter int CNT_W  = 4,
  parameter int DISP_W = 4,
  parameter int IDW    = 2,
  parameter int CNT_OW = 3
) (
  input logic                clk,
  input logic                rst,
  input logic [NT*CNT_W-1:0] avail_cnt,
  input logic                winner_valid,
  input logic [CNT_OW-1:0]   winner_cnt,
  input logic [NT*IDW-1:0]   rank_order,
  input logic                no_insn
);

  logic [NT-1:0] seen;

  always_comb begin
    seen = '0;
    for (int p = 0; p < NT; p++) seen[rank_order[p*IDW +: IDW]] = 1'b1;
  end

  p_cnt_cap_r1: assert property (@(posedge clk) disable iff (rst)
    int'(winner_cnt) <= DISP_W);

  p_valid_cnt_r2: assert property (@(posedge clk) disable iff (rst)
    winner_valid |-> (winner_cnt != '0));

  p_some_elig_r2: assert property (@(posedge clk) disable iff (rst)
    (avail_cnt != '0) |=> winner_valid);

  p_perm_r6: assert property (@(posedge clk) disable iff (rst)
    $countones(seen) == NT);

  p_none_elig_r8: assert property (@(posedge clk) disable iff (rst)
    (avail_cnt == '0) |=> (no_insn && !winner_valid));

endmodule

bind dispatch_thread_arbiter dta_arb_chk #(
  .NT(NT), .CNT_W(CNT_W), .DISP_W(DISP_W), .IDW(IDW), .CNT_OW(CNT_OW)
) chk_i (
  .clk          (clk),
  .rst          (rst),
  .avail_cnt    (avail_cnt),
  .winner_valid (winner_valid),
  .winner_cnt   (winner_cnt),
  .rank_order   (rank_order),
  .no_insn      (no_insn)
);

// File: tb/dispatch_thread_arbiter_tb_top.sv
module dispatch_thread_arbiter_tb_top;
  localparam int NT = 4, CNT_W = 4, OCC_W = 6, TS_W = 16, DISP_W = 4, IQ_SLOTS = 32;
  localparam int IDW = $clog2(NT);
  localparam int CNT_OW = $clog2(DISP_W + 1);
  localparam int MASK = (1 << TS_W) - 1;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst;
  logic policy_occ;
  logic [TS_W-1:0] cycle_now;
  logic [NT*CNT_W-1:0] avail_cnt;
  logic [NT*OCC_W-1:0] iq_occ, occ_bias;
  logic disp_done;
  logic [IDW-1:0] disp_done_id;
  logic winner_valid, no_insn;
  logic [IDW-1:0] winner_id;
  logic [CNT_OW-1:0] winner_cnt;
  logic [NT*IDW-1:0] rank_order;

  dispatch_thread_arbiter dut_i (
    .clk(clk), .rst(rst), .policy_occ(policy_occ), .cycle_now(cycle_now),
    .avail_cnt(avail_cnt), .iq_occ(iq_occ), .occ_bias(occ_bias),
    .disp_done(disp_done), .disp_done_id(disp_done_id),
    .winner_valid(winner_valid), .winner_id(winner_id), .winner_cnt(winner_cnt),
    .rank_order(rank_order), .no_insn(no_insn)
  );

  int n_cmp = 0, n_bad = 0;
  string cur_req = "R10";
  bit finished = 0;

  int a_avail[NT], a_occ[NT], a_bias[NT];
  int cyc;
  int m_last[NT];
  int m_sc[NT], m_ag[NT];
  bit m_el[NT];
  bit e_valid, e_noinsn;
  int e_id, e_cnt;
  int e_order[NT];

  function automatic bit better(int a, int b);
    if (m_el[a] != m_el[b]) return m_el[a];
    if (m_sc[a] != m_sc[b]) return m_sc[a] > m_sc[b];
    if (m_ag[a] != m_ag[b]) return m_ag[a] > m_ag[b];
    return a < b;
  endfunction

  task automatic drive();
    for (int t = 0; t < NT; t++) begin
      avail_cnt[t*CNT_W +: CNT_W] = CNT_W'(a_avail[t]);
      iq_occ[t*OCC_W +: OCC_W]    = OCC_W'(a_occ[t]);
      occ_bias[t*OCC_W +: OCC_W]  = OCC_W'(a_bias[t]);
    end
    cycle_now = TS_W'(cyc);
  endtask

  task automatic model_edge();
    bit used[NT];
    if (rst) begin
      for (int t = 0; t < NT; t++) begin m_last[t] = 0; e_order[t] = t; end
      e_valid = 0; e_noinsn = 1; e_id = 0; e_cnt = 0;
      return;
    end
    for (int t = 0; t < NT; t++) begin
      int tot;
      used[t] = 0;
      m_el[t] = a_avail[t] > 0;
      m_ag[t] = (cyc - m_last[t]) & MASK;
      tot = a_occ[t] + a_bias[t];
      if (policy_occ) m_sc[t] = (tot >= IQ_SLOTS) ? 0 : IQ_SLOTS - tot;
      else            m_sc[t] = m_ag[t];
    end
    for (int p = 0; p < NT; p++) begin
      int best = -1;
      for (int t = 0; t < NT; t++)
        if (!used[t] && (best < 0 || better(t, best))) best = t;
      e_order[p] = best;
      used[best] = 1;
    end
    e_id = e_order[0];
    e_valid = m_el[e_id];
    e_noinsn = !e_valid;
    e_cnt = (a_avail[e_id] > DISP_W) ? DISP_W : a_avail[e_id];
    if (disp_done) m_last[disp_done_id] = cyc & MASK;
  endtask

  task automatic compare();
    logic [NT*IDW-1:0] eo;
    for (int p = 0; p < NT; p++) eo[p*IDW +: IDW] = IDW'(e_order[p]);
    n_cmp++;
    if (winner_valid !== e_valid || no_insn !== e_noinsn || int'(winner_id) != e_id ||
        int'(winner_cnt) != e_cnt || rank_order !== eo) begin
      n_bad++;
      $display("FAIL %s: act v=%0b id=%0d cnt=%0d ord=%h ni=%0b exp v=%0b id=%0d cnt=%0d ord=%h ni=%0b",
               cur_req, winner_valid, winner_id, winner_cnt, rank_order, no_insn,
               e_valid, e_id, e_cnt, eo, e_noinsn);
    end
  endtask

  task automatic step();
    drive();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare();
    cyc = (cyc + 1) & MASK;
  endtask

  task automatic set_all(int av, int oc, int bi);
    for (int t = 0; t < NT; t++) begin a_avail[t] = av; a_occ[t] = oc; a_bias[t] = bi; end
  endtask

  initial begin
    for (int i = 0; i < 100000; i++) begin
      @(posedge clk);
      if (finished) break;
    end
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: act=hung exp=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    rst = 1; policy_occ = 0; disp_done = 0; disp_done_id = '0; cyc = 0;
    set_all(0, 0, 0);
    // R10: reset state
    cur_req = "R10";
    step(); step();
    rst = 0;

    // R8: nothing available
    cur_req = "R8";
    step(); step();

    // R1: single thread with more than the dispatch width, then fewer
    cur_req = "R1";
    a_avail[2] = 9; step();
    a_avail[2] = 2; step();
    a_avail[2] = 4; step();

    // R2: eligible thread beats an ineligible one with a better score
    cur_req = "R2";
    policy_occ = 1; set_all(0, 0, 0);
    a_avail[3] = 1; a_occ[3] = 30; step();
    a_avail[1] = 3; a_occ[1] = 0; a_avail[3] = 0; step();

    // R3: occupancy scores order the threads
    cur_req = "R3";
    set_all(5, 0, 0);
    a_occ[0] = 20; a_occ[1] = 3; a_bias[1] = 2; a_occ[2] = 10; a_occ[3] = 1; a_bias[3] = 10;
    step(); step();

    // R4: saturation at zero
    cur_req = "R4";
    a_occ[0] = 40; a_bias[0] = 30; a_occ[1] = 63; a_bias[1] = 63;
    a_occ[2] = 32; a_bias[2] = 0; a_occ[3] = 31; a_bias[3] = 0;
    step();

    // R9: stamp threads through dispatch reports
    cur_req = "R9";
    policy_occ = 0; set_all(1, 0, 0);
    cyc = 100;
    disp_done = 1; disp_done_id = 2; step();
    disp_done_id = 0; step();
    disp_done_id = 1; step();
    disp_done = 0; step(); step();

    // R5: age rule ranks oldest first
    cur_req = "R5";
    a_avail[3] = 0; step();
    a_avail[3] = 6; step();

    // R7: tied occupancy scores resolved by age, then index
    cur_req = "R7";
    policy_occ = 1; set_all(2, 4, 1);
    step();
    disp_done = 1; disp_done_id = 3; step();
    disp_done_id = 2; step();
    disp_done = 0; step();

    // R6: random mix, timestamps crossing the wrap
    cur_req = "R6";
    cyc = 16'hFFF0;
    for (int k = 0; k < 400; k++) begin
      policy_occ = $urandom_range(0, 1);
      for (int t = 0; t < NT; t++) begin
        a_avail[t] = ($urandom_range(0, 3) == 0) ? 0 : $urandom_range(1, 15);
        a_occ[t] = $urandom_range(0, 63);
        a_bias[t] = $urandom_range(0, 15);
      end
      disp_done = $urandom_range(0, 1);
      disp_done_id = IDW'($urandom_range(0, NT - 1));
      step();
    end
    disp_done = 0;

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule